// File: doc/BRIEF.md
# Machine State Register Update Unit

This block holds a 64-bit machine state word. It commits the masked updates that four privileged-flow operations apply to that word. Two of the operations return from an interrupt: one uses the ordinary saved-state pair and one uses the hypervisor saved-state pair. The other two write the word from a general operand: one writes the low word and one writes the full doubleword. Each operation copies its own set of bit ranges. A few bits are forced high when the source's bit 14 is set. A 3-bit transaction-state field refuses one specific transition. In the ordinary return, bit 60 of the old word decides where the new bit 12 comes from.

An operation is presented for one cycle with `op_valid` high. The result is visible on `msr_q` after the next rising edge. The unit accepts one operation every cycle and never stalls, so there is no ready signal and no back-pressure: the caller owns pacing. The return operations also output the address to resume at, with a one-cycle `nia_valid` pulse. A doubleword write issued from problem state is refused and reported on `priv_fault`. The current word can be read at any time on `msr_q`.

Top module: `msr_update_unit`

## Requirements
- R1: While `rst` is high at a rising edge, `msr_q` and `nia_q` become zero and `nia_valid` and `priv_fault` become 0.
- R2: `op_sel` encodes 0 = return, 1 = hypervisor return, 2 = word write, 3 = doubleword write. An operation takes effect at the rising edge where `op_valid` is 1, and the result shows on `msr_q` after that edge. Without `op_valid` the word keeps its value, whatever the other inputs do.
- R3: Bits 34:32 are the transaction-state field. For the return, the hypervisor return and the doubleword write with `l_bit`=0, the field takes the new source value. The one exception is when the current field is 2 and the new value is 0: then the field is kept.
- R4: Doubleword write, `l_bit`=0: bits 5 and 4 become src[n] OR src[14]. Bits 63:61, 59:35, 31:16, 14:13, 11:6 and 3:1 are copied from `src`. Bits 60, 15, 12 and 0 are kept.
- R5: Word write or doubleword write with `l_bit`=1: only bits 15 and 1 are written from `src`. Every other bit is kept.
- R6: Word write, `l_bit`=0: bits 15, 5 and 4 become src[n] OR src[14]. Bits 31:16, 14:13, 11:6 and 3:1 are copied from `src`. Bits 63:32, 12 and 0 are kept.
- R7: Return: new bit 12 is `srr1[12]` when old bit 60 is 1, and old bit 12 otherwise. New bit 60 is old bit 60 AND `srr1[60]`.
- R8: Return: bits 15, 5 and 4 become srr1[n] OR srr1[14]. Bits 63:61, 59:35, 31, 26:22, 14:13, 11:6 and 3:0 are copied from `srr1`. Bits 30:27 and 21:16 are kept.
- R9: Hypervisor return: bits 15, 5 and 4 become hsrr1[n] OR hsrr1[14]. Bits 63:35, 31, 26:22, 14:6 and 3:0 are copied from `hsrr1`. Bits 30:27 and 21:16 are kept.
- R10: After a return, `nia_q` holds the matching saved address (`srr0` or `hsrr0`) with bits 1:0 cleared, and `nia_valid` is 1 for exactly one cycle. Write operations never raise `nia_valid`.
- R11: A doubleword write with `prob_state`=1 leaves the word unchanged and raises `priv_fault` for exactly one cycle. No other operation raises `priv_fault`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | One-cycle operation strobe |
| op_sel | input | 2 | Operation code (see R2) |
| l_bit | input | 1 | Narrow-write select for the two write operations |
| prob_state | input | 1 | Caller runs in problem (user) state |
| src | input | 64 | Source operand for write operations |
| srr0 | input | 64 | Saved resume address, ordinary return |
| srr1 | input | 64 | Saved state word, ordinary return |
| hsrr0 | input | 64 | Saved resume address, hypervisor return |
| hsrr1 | input | 64 | Saved state word, hypervisor return |
| msr_q | output | 64 | Current machine state word |
| nia_q | output | 64 | Resume address from the last return |
| nia_valid | output | 1 | One-cycle pulse: `nia_q` is new |
| priv_fault | output | 1 | One-cycle pulse: refused privileged write |

## Verification
The bench drives the transaction-state field into state 2 and then presents 0 through every operation that obeys the hold rule. A design that applied the rule everywhere, or nowhere, would either leave state 2 on a word write or move the field to 0. It runs the ordinary return with old bit 60 both clear and set, so swapping the selector or using the updated bit 60 makes bit 12 or bit 60 wrong. It sets source bit 14 with the forced bits clear, and issues narrow writes over a busy word. A mask that is off by one range shows up as a stray bit in the kept ranges 30:27, 21:16 or 63:32. Refused doubleword writes check that the word stays put and that the fault and resume pulses last exactly one cycle.

// File: rtl/msr_pkg.sv
package msr_pkg;

  localparam int XLEN = 64;
  localparam int TSW  = 3;

  typedef enum logic [1:0] {
    OP_RET  = 2'd0,
    OP_HRET = 2'd1,
    OP_MOVW = 2'd2,
    OP_MOVD = 2'd3
  } msr_op_e;

  // bit positions that the merge rules depend on
  localparam int TS_HI     = 34;
  localparam int TS_LO     = 32;
  localparam int ORSRC_BIT = 14;
  localparam int FRC_HI    = 15;
  localparam int FRC_MID   = 5;
  localparam int FRC_LO    = 4;
  localparam int GATE_BIT  = 60;
  localparam int PICK_BIT  = 12;
  localparam int NARROW_HI = 15;
  localparam int NARROW_LO = 1;
  localparam logic [TSW-1:0] TS_LOCK = 3'd2;

  function automatic logic [XLEN-1:0] rng(input int hi, input int lo);
    logic [XLEN-1:0] m;
    m = '0;
    for (int i = lo; i <= hi; i++) m[i] = 1'b1;
    return m;
  endfunction

  localparam logic [XLEN-1:0] RET_COPY  = rng(63, 61) | rng(59, 35) | rng(31, 31) |
                                          rng(26, 22) | rng(14, 13) | rng(11, 6) | rng(3, 0);
  localparam logic [XLEN-1:0] HRET_COPY = rng(63, 35) | rng(31, 31) | rng(26, 22) |
                                          rng(14, 6)  | rng(3, 0);
  localparam logic [XLEN-1:0] MOVD_COPY = rng(63, 61) | rng(59, 35) | rng(31, 16) |
                                          rng(14, 13) | rng(11, 6)  | rng(3, 1);
  localparam logic [XLEN-1:0] MOVW_COPY = rng(31, 16) | rng(14, 13) | rng(11, 6) | rng(3, 1);
  localparam logic [XLEN-1:0] NARROW_M  = rng(NARROW_HI, NARROW_HI) | rng(NARROW_LO, NARROW_LO);
  localparam logic [XLEN-1:0] ALIGN_M   = ~XLEN'(3);

  function automatic logic [XLEN-1:0] mask_merge(input logic [XLEN-1:0] old_w,
                                                  input logic [XLEN-1:0] new_w,
                                                  input logic [XLEN-1:0] m);
    return (old_w & ~m) | (new_w & m);
  endfunction

  // transaction-state field: a move from the locked state to zero is refused
  function automatic logic [TSW-1:0] ts_next(input logic [TSW-1:0] cur,
                                              input logic [TSW-1:0] cand);
    return (cur == TS_LOCK && cand == '0) ? cur : cand;
  endfunction

endpackage

// File: rtl/msr_return_merge.sv
module msr_return_merge
  import msr_pkg::*;
#(
  parameter bit HYPER = 1'b0
) (
  input  logic [XLEN-1:0] old_msr,
  input  logic [XLEN-1:0] saved_st,
  input  logic [XLEN-1:0] saved_pc,
  output logic [XLEN-1:0] nxt_msr,
  output logic [XLEN-1:0] nxt_pc
);

  assign nxt_pc = saved_pc & ALIGN_M;

  generate
    if (HYPER) begin : g_hyp
      always_comb begin
        nxt_msr = mask_merge(old_msr, saved_st, HRET_COPY);
        nxt_msr[TS_HI:TS_LO] = ts_next(old_msr[TS_HI:TS_LO], saved_st[TS_HI:TS_LO]);
        nxt_msr[FRC_HI]  = saved_st[FRC_HI]  | saved_st[ORSRC_BIT];
        nxt_msr[FRC_MID] = saved_st[FRC_MID] | saved_st[ORSRC_BIT];
        nxt_msr[FRC_LO]  = saved_st[FRC_LO]  | saved_st[ORSRC_BIT];
      end
    end else begin : g_std
      always_comb begin
        nxt_msr = mask_merge(old_msr, saved_st, RET_COPY);
        nxt_msr[TS_HI:TS_LO] = ts_next(old_msr[TS_HI:TS_LO], saved_st[TS_HI:TS_LO]);
        nxt_msr[FRC_HI]  = saved_st[FRC_HI]  | saved_st[ORSRC_BIT];
        nxt_msr[FRC_MID] = saved_st[FRC_MID] | saved_st[ORSRC_BIT];
        nxt_msr[FRC_LO]  = saved_st[FRC_LO]  | saved_st[ORSRC_BIT];
        // both use the pre-update gate bit
        nxt_msr[PICK_BIT] = old_msr[GATE_BIT] ? saved_st[PICK_BIT] : old_msr[PICK_BIT];
        nxt_msr[GATE_BIT] = old_msr[GATE_BIT] & saved_st[GATE_BIT];
      end
    end
  endgenerate

endmodule

// File: rtl/msr_move_merge.sv
module msr_move_merge
  import msr_pkg::*;
#(
  parameter bit DOUBLE = 1'b0
) (
  input  logic [XLEN-1:0] old_msr,
  input  logic [XLEN-1:0] src,
  input  logic            l_bit,
  output logic [XLEN-1:0] nxt_msr
);

  generate
    if (DOUBLE) begin : g_dw
      always_comb begin
        if (l_bit) begin
          nxt_msr = mask_merge(old_msr, src, NARROW_M);
        end else begin
          nxt_msr = mask_merge(old_msr, src, MOVD_COPY);
          nxt_msr[TS_HI:TS_LO] = ts_next(old_msr[TS_HI:TS_LO], src[TS_HI:TS_LO]);
          nxt_msr[FRC_MID] = src[FRC_MID] | src[ORSRC_BIT];
          nxt_msr[FRC_LO]  = src[FRC_LO]  | src[ORSRC_BIT];
        end
      end
    end else begin : g_w
      always_comb begin
        if (l_bit) begin
          nxt_msr = mask_merge(old_msr, src, NARROW_M);
        end else begin
          nxt_msr = mask_merge(old_msr, src, MOVW_COPY);
          nxt_msr[FRC_HI]  = src[FRC_HI]  | src[ORSRC_BIT];
          nxt_msr[FRC_MID] = src[FRC_MID] | src[ORSRC_BIT];
          nxt_msr[FRC_LO]  = src[FRC_LO]  | src[ORSRC_BIT];
        end
      end
    end
  endgenerate

endmodule

// File: rtl/msr_commit.sv
module msr_commit
  import msr_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            load_msr,
  input  logic [XLEN-1:0] msr_nxt,
  input  logic            ret_fire,
  input  logic [XLEN-1:0] pc_nxt,
  input  logic            fault_fire,
  output logic [XLEN-1:0] msr_q,
  output logic [XLEN-1:0] nia_q,
  output logic            nia_valid,
  output logic            priv_fault
);

  always_ff @(posedge clk) begin
    if (rst) begin
      msr_q      <= '0;
      nia_q      <= '0;
      nia_valid  <= 1'b0;
      priv_fault <= 1'b0;
    end else begin
      if (load_msr) msr_q <= msr_nxt;
      if (ret_fire) nia_q <= pc_nxt;
      nia_valid  <= ret_fire;
      priv_fault <= fault_fire;
    end
  end

endmodule

// File: rtl/msr_update_unit.sv
module msr_update_unit
  import msr_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            op_valid,
  input  logic [1:0]      op_sel,
  input  logic            l_bit,
  input  logic            prob_state,
  input  logic [XLEN-1:0] src,
  input  logic [XLEN-1:0] srr0,
  input  logic [XLEN-1:0] srr1,
  input  logic [XLEN-1:0] hsrr0,
  input  logic [XLEN-1:0] hsrr1,
  output logic [XLEN-1:0] msr_q,
  output logic [XLEN-1:0] nia_q,
  output logic            nia_valid,
  output logic            priv_fault
);

  msr_op_e op_e;
  assign op_e = msr_op_e'(op_sel);

  logic [XLEN-1:0] ret_msr, hret_msr, movw_msr, movd_msr;
  logic [XLEN-1:0] ret_pc, hret_pc;
  logic [XLEN-1:0] msr_nxt, pc_nxt;
  logic            is_ret, fault_fire, load_msr, ret_fire;

  msr_return_merge #(.HYPER(1'b0)) i_ret (
    .old_msr(msr_q), .saved_st(srr1), .saved_pc(srr0),
    .nxt_msr(ret_msr), .nxt_pc(ret_pc));

  msr_return_merge #(.HYPER(1'b1)) i_hret (
    .old_msr(msr_q), .saved_st(hsrr1), .saved_pc(hsrr0),
    .nxt_msr(hret_msr), .nxt_pc(hret_pc));

  msr_move_merge #(.DOUBLE(1'b0)) i_movw (
    .old_msr(msr_q), .src(src), .l_bit(l_bit), .nxt_msr(movw_msr));

  msr_move_merge #(.DOUBLE(1'b1)) i_movd (
    .old_msr(msr_q), .src(src), .l_bit(l_bit), .nxt_msr(movd_msr));

  always_comb begin
    unique case (op_e)
      OP_RET:  msr_nxt = ret_msr;
      OP_HRET: msr_nxt = hret_msr;
      OP_MOVW: msr_nxt = movw_msr;
      default: msr_nxt = movd_msr;
    endcase
  end

  assign is_ret     = (op_e == OP_RET) || (op_e == OP_HRET);
  assign pc_nxt     = (op_e == OP_HRET) ? hret_pc : ret_pc;
  assign fault_fire = op_valid && (op_e == OP_MOVD) && prob_state;
  assign load_msr   = op_valid && !fault_fire;
  assign ret_fire   = op_valid && is_ret;

  msr_commit i_commit (
    .clk(clk), .rst(rst),
    .load_msr(load_msr), .msr_nxt(msr_nxt),
    .ret_fire(ret_fire), .pc_nxt(pc_nxt),
    .fault_fire(fault_fire),
    .msr_q(msr_q), .nia_q(nia_q), .nia_valid(nia_valid), .priv_fault(priv_fault));

endmodule

// File: rtl/msr_update_chk.sv
module msr_update_chk
  import msr_pkg::*;
(
  input logic            clk,
  input logic            rst,
  input logic            op_valid,
  input logic [1:0]      op_sel,
  input logic            l_bit,
  input logic            prob_state,
  input logic [XLEN-1:0] msr_q,
  input logic [XLEN-1:0] nia_q,
  input logic            nia_valid,
  input logic            priv_fault
);

  // R1
  reset_clears_chk: assert property (@(posedge clk)
    rst |=> (msr_q == '0 && nia_q == '0 && !nia_valid && !priv_fault));

  // R2
  idle_holds_chk: assert property (@(posedge clk) disable iff (rst)
    !op_valid |=> $stable(msr_q));

  // R5
  narrow_keeps_rest_chk: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_sel[1] && l_bit && !(op_sel == 2'd3 && prob_state))
    |=> ((msr_q & ~NARROW_M) == ($past(msr_q) & ~NARROW_M)));

  // R10
  nia_aligned_chk: assert property (@(posedge clk) disable iff (rst)
    nia_valid |-> (nia_q[1:0] == 2'b00));

  // R10
  nia_from_return_chk: assert property (@(posedge clk) disable iff (rst)
    (op_valid && !op_sel[1]) |=> nia_valid);

  // R10
  no_nia_on_write_chk: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_sel[1]) |=> !nia_valid);

  // R11
  fault_raised_chk: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_sel == 2'd3 && prob_state) |=> (priv_fault && $stable(msr_q)));

  // R11
  fault_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
    !(priv_fault && nia_valid));

endmodule

bind msr_update_unit msr_update_chk i_msr_update_chk (
  .clk(clk), .rst(rst), .op_valid(op_valid), .op_sel(op_sel), .l_bit(l_bit),
  .prob_state(prob_state), .msr_q(msr_q), .nia_q(nia_q),
  .nia_valid(nia_valid), .priv_fault(priv_fault));

// File: tb/test_msr_update_unit.sv
`timescale 1ns/1ps
module test_msr_update_unit;

  logic        clk = 1'b0;
  logic        rst;
  logic        op_valid;
  logic [1:0]  op_sel;
  logic        l_bit, prob_state;
  logic [63:0] src, srr0, srr1, hsrr0, hsrr1;
  logic [63:0] msr_q, nia_q;
  logic        nia_valid, priv_fault;

  int checks = 0;
  int errors = 0;
  logic [63:0] exp_msr;

  always #5 clk = ~clk;

  msr_update_unit i_msr_update_unit (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_sel(op_sel), .l_bit(l_bit),
    .prob_state(prob_state), .src(src), .srr0(srr0), .srr1(srr1),
    .hsrr0(hsrr0), .hsrr1(hsrr1), .msr_q(msr_q), .nia_q(nia_q),
    .nia_valid(nia_valid), .priv_fault(priv_fault));

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  function automatic logic [63:0] rnd64();
    return {$urandom(), $urandom()};
  endfunction

  // reference model written directly from the requirement text
  function automatic logic [63:0] model(input logic [1:0] op, input logic l,
      input logic [63:0] s, input logic [63:0] s1, input logic [63:0] h1,
      input logic [63:0] old, input logic prob);
    logic [63:0] m;
    m = old;
    case (op)
      2'd0: begin // R7 R8 R3
        m[12] = old[60] ? s1[12] : old[12];
        m[60] = old[60] & s1[60];
        if (!(old[34:32] == 3'd2 && s1[34:32] == 3'd0)) m[34:32] = s1[34:32];
        m[15] = s1[15] | s1[14];
        m[5]  = s1[5]  | s1[14];
        m[4]  = s1[4]  | s1[14];
        m[63:61] = s1[63:61]; m[59:35] = s1[59:35]; m[31] = s1[31];
        m[26:22] = s1[26:22]; m[14:13] = s1[14:13]; m[11:6] = s1[11:6];
        m[3:0] = s1[3:0];
      end
      2'd1: begin // R9 R3
        if (!(old[34:32] == 3'd2 && h1[34:32] == 3'd0)) m[34:32] = h1[34:32];
        m[15] = h1[15] | h1[14];
        m[5]  = h1[5]  | h1[14];
        m[4]  = h1[4]  | h1[14];
        m[63:35] = h1[63:35]; m[31] = h1[31]; m[26:22] = h1[26:22];
        m[14:6] = h1[14:6]; m[3:0] = h1[3:0];
        m[34:32] = (old[34:32] == 3'd2 && h1[34:32] == 3'd0) ? old[34:32] : h1[34:32];
      end
      2'd2: begin
        if (l) begin m[15] = s[15]; m[1] = s[1]; end // R5
        else begin // R6
          m[15] = s[15] | s[14]; m[5] = s[5] | s[14]; m[4] = s[4] | s[14];
          m[31:16] = s[31:16]; m[14:13] = s[14:13]; m[11:6] = s[11:6]; m[3:1] = s[3:1];
        end
      end
      default: begin
        if (prob) m = old; // R11
        else if (l) begin m[15] = s[15]; m[1] = s[1]; end
        else begin // R4 R3
          if (!(old[34:32] == 3'd2 && s[34:32] == 3'd0)) m[34:32] = s[34:32];
          m[5] = s[5] | s[14]; m[4] = s[4] | s[14];
          m[63:61] = s[63:61]; m[59:35] = s[59:35]; m[31:16] = s[31:16];
          m[14:13] = s[14:13]; m[11:6] = s[11:6]; m[3:1] = s[3:1];
        end
      end
    endcase
    return m;
  endfunction

  task automatic run_op(input logic [1:0] op, input logic l, input logic [63:0] s,
      input logic [63:0] s0, input logic [63:0] s1, input logic [63:0] h0,
      input logic [63:0] h1, input logic prob, input string req);
    logic [63:0] nxt;
    logic [63:0] enia;
    @(negedge clk);
    op_sel = op; l_bit = l; src = s; srr0 = s0; srr1 = s1;
    hsrr0 = h0; hsrr1 = h1; prob_state = prob; op_valid = 1'b1;
    nxt  = model(op, l, s, s1, h1, exp_msr, prob);
    enia = ((op == 2'd1) ? h0 : s0) & ~64'd3;
    @(negedge clk);
    op_valid = 1'b0;
    src = rnd64(); srr1 = rnd64(); hsrr1 = rnd64();
    check(req, msr_q, nxt);
    check("R10 nia_valid", {63'd0, nia_valid}, {63'd0, op < 2'd2});
    if (op < 2'd2) check("R10 nia", nia_q, enia);
    check("R11 priv_fault", {63'd0, priv_fault}, {63'd0, op == 2'd3 && prob});
    @(negedge clk);
    check("R2 idle hold", msr_q, nxt);
    check("R10 R11 pulse width", {62'd0, nia_valid, priv_fault}, 64'd0);
    exp_msr = nxt;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [63:0] v;
    void'($urandom(32'd20240611));
    rst = 1'b1; op_valid = 1'b0; op_sel = 2'd0; l_bit = 1'b0; prob_state = 1'b0;
    src = '0; srr0 = '0; srr1 = '0; hsrr0 = '0; hsrr1 = '0;
    exp_msr = '0;
    repeat (3) @(negedge clk);
    check("R1 msr reset", msr_q, 64'd0);
    check("R1 pulses reset", {62'd0, nia_valid, priv_fault}, 64'd0);
    rst = 1'b0;

    // R2: noise on inputs without a strobe
    @(negedge clk); src = '1; srr1 = '1; hsrr1 = '1; op_sel = 2'd3;
    @(negedge clk); @(negedge clk);
    check("R2 no strobe", msr_q, 64'd0);

    // R3: enter locked state, then try to clear it through each honoring op
    run_op(2'd3, 1'b0, 64'h0000_0002_0000_0000, '0, '0, '0, '0, 1'b0, "R3 enter lock");
    check("R3 field", {61'd0, msr_q[34:32]}, 64'd2);
    run_op(2'd3, 1'b0, 64'h0000_0000_0000_4000, '0, '0, '0, '0, 1'b0, "R3 R4 hold movd");
    check("R3 field kept", {61'd0, msr_q[34:32]}, 64'd2);
    run_op(2'd0, 1'b0, '0, 64'h13, 64'hFFFF_FFF8_FFFF_FFFF, '0, '0, 1'b0, "R3 R8 hold ret");
    check("R3 field kept ret", {61'd0, msr_q[34:32]}, 64'd2);
    run_op(2'd1, 1'b0, '0, '0, '0, 64'h27, 64'h0000_0000_0000_0000, 1'b0, "R3 R9 hold hret");
    check("R3 field kept hret", {61'd0, msr_q[34:32]}, 64'd2);
    run_op(2'd1, 1'b0, '0, '0, '0, 64'h5, 64'h0000_0005_0000_0000, 1'b0, "R3 R9 leave lock");
    check("R3 field moved", {61'd0, msr_q[34:32]}, 64'd5);
    run_op(2'd3, 1'b0, '0, '0, '0, '0, '0, 1'b0, "R3 R4 to zero");
    check("R3 field zero", {61'd0, msr_q[34:32]}, 64'd0);

    // R7: gate bit clear, then set
    run_op(2'd0, 1'b0, '0, 64'h8, 64'h1000_0000_0000_1000, '0, '0, 1'b0, "R7 gate clear");
    check("R7 bit12 kept", {63'd0, msr_q[12]}, 64'd0);
    check("R7 bit60 and", {63'd0, msr_q[60]}, 64'd0);
    run_op(2'd1, 1'b0, '0, '0, '0, 64'h4, 64'h1000_0000_0000_0000, 1'b0, "R9 set gate");
    run_op(2'd0, 1'b0, '0, 64'hC, 64'h0000_0000_0000_1000, '0, '0, 1'b0, "R7 gate set");
    check("R7 bit12 picked", {63'd0, msr_q[12]}, 64'd1);
    check("R7 bit60 cleared", {63'd0, msr_q[60]}, 64'd0);

    // R6 R5: bit14 forcing and narrow writes over a busy word
    run_op(2'd1, 1'b0, '0, '0, '0, '0, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0, "R9 fill");
    run_op(2'd2, 1'b0, 64'h0000_0000_0000_4000, '0, '0, '0, '0, 1'b0, "R6 force bits");
    run_op(2'd2, 1'b1, 64'h0000_0000_0000_0000, '0, '0, '0, '0, 1'b0, "R5 narrow word");
    run_op(2'd3, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF, '0, '0, '0, '0, 1'b0, "R5 narrow dword");

    // R11: refused writes
    run_op(2'd3, 1'b0, 64'h0, '0, '0, '0, '0, 1'b1, "R11 refused");
    run_op(2'd3, 1'b1, 64'h0, '0, '0, '0, '0, 1'b1, "R11 refused narrow");
    run_op(2'd2, 1'b0, 64'h0, '0, '0, '0, '0, 1'b1, "R6 R11 word not privileged");

    // random mix
    for (int i = 0; i < 400; i++) begin
      logic [1:0] op;
      logic [63:0] s, s1, h1;
      op = 2'($urandom_range(0, 3));
      s = rnd64(); s1 = rnd64(); h1 = rnd64();
      if ($urandom_range(0, 1) == 0) begin
        v = {61'd0, ($urandom_range(0, 1) == 0) ? 3'd0 : 3'd2};
        s[34:32] = v[2:0]; s1[34:32] = v[2:0]; h1[34:32] = v[2:0];
      end
      run_op(op, 1'($urandom_range(0, 1)), s, rnd64(), s1, rnd64(), h1,
             ($urandom_range(0, 3) == 0),
             (op == 2'd0) ? "R8 random ret" : (op == 2'd1) ? "R9 random hret" :
             (op == 2'd2) ? "R6 random word" : "R4 random dword");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule